// File: doc/BRIEF.md
# Early-terminating iterative integer divider

This block divides one integer by another over several clock cycles. It returns both quotient and remainder. A select input chooses between two's-complement and unsigned interpretation of the operands. The block is meant to sit beside a processor's execute stages and hold its operation slot for as long as the division runs.

The block uses restoring shift-subtract. It does not always run a fixed number of steps. During a setup cycle it takes the magnitude of the dividend, counts that magnitude's leading zeros, and pre-shifts the dividend past them. It then runs only as many iterations as the dividend has significant bits. A final cycle applies the result signs and raises a one-cycle completion pulse. Small dividends therefore finish early, and the occupancy of the block can be predicted exactly from the dividend alone.

Division by zero runs the full iteration count and returns a defined result. The overflow case of the most negative value divided by minus one also returns a defined result, and needs no separate path.

Top module: `xdiv_unit`

## Requirements
- R1: A start accepted while idle raises busy on the next cycle. Busy stays high through the cycle in which done is high. Done is high for exactly one cycle, and busy is low on the cycle after done.
- R2: With a nonzero divisor and a nonzero dividend, busy stays high for WIDTH minus the leading-zero count of the dividend's magnitude, plus 2 cycles. The magnitude is the absolute value when signed is 1 and the raw value when signed is 0.
- R3: A zero dividend with a nonzero divisor finishes in 2 busy cycles, with quotient 0 and remainder 0.
- R4: When the signed select is 0, the quotient is floor(dividend / divisor) and the remainder is dividend mod divisor, both taken as unsigned numbers.
- R5: When the signed select is 1, the quotient is truncated toward zero and is negative exactly when the operand signs differ. The remainder carries the sign of the dividend.
- R6: A zero divisor returns a quotient of all ones and a remainder equal to the dividend as given. This takes WIDTH+2 busy cycles in either mode.
- R7: In signed mode, the most negative value divided by all ones (minus one) returns the most negative value as quotient and 0 as remainder.
- R8: A start that arrives while busy is high is ignored. The operation already in progress completes with its own operands and its own cycle count.
- R9: From the cycle of done until the next start is accepted, quotient and remainder hold their values, whatever the operand inputs do.
- R10: After reset, busy and done are 0 and quotient and remainder read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a division; honoured only while idle |
| signed_i | input | 1 | 1: two's-complement operands, 0: unsigned |
| dividend_i | input | WIDTH | Dividend, sampled with an accepted start |
| divisor_i | input | WIDTH | Divisor, sampled with an accepted start |
| busy_o | output | 1 | High while an operation occupies the block |
| done_o | output | 1 | One-cycle pulse when results are valid |
| quotient_o | output | WIDTH | Quotient, valid from done until the next start |
| remainder_o | output | WIDTH | Remainder, valid from done until the next start |

## Verification
The hardest cases to reach are those where the special results come out of the ordinary iteration rather than from a separate path. These are the all-ones quotient for a zero divisor, the most negative quotient for the overflow pair, and the magnitude of the most negative dividend, which has no leading zeros. The bench reaches them by running every operand pair of a 6-bit instance in both modes. Each pair is checked for its result values and for its exact busy-cycle count. An extra run pulses start in the middle of a long operation, with different operands, and confirms the first result is unaffected.

// File: rtl/xdiv_pkg.sv
package xdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_ITER  = 2'd2,
        ST_FIX   = 2'd3
    } xdiv_state_e;

endpackage

// File: rtl/xdiv_abs.sv
module xdiv_abs #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic             neg_i,
    output logic [WIDTH-1:0] mag_o
);
    // Two's-complement negation when the operand is negative in signed mode.
    assign mag_o = neg_i ? (~val_i + 1'b1) : val_i;
endmodule

// File: rtl/xdiv_lzc.sv
module xdiv_lzc #(
    parameter int WIDTH = 32,
    parameter int CW    = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] val_i,
    output logic [CW-1:0]    lz_o
);
    // Scan upward; the highest set bit overwrites earlier hits.
    always_comb begin
        lz_o = CW'(WIDTH);
        for (int i = 0; i < WIDTH; i++) begin
            if (val_i[i]) begin
                lz_o = CW'(WIDTH - 1 - i);
            end
        end
    end
endmodule

// File: rtl/xdiv_step.sv
module xdiv_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] rem_i,
    input  logic             bit_i,
    input  logic [WIDTH-1:0] dsr_i,
    output logic [WIDTH-1:0] rem_o,
    output logic             qbit_o
);
    logic [WIDTH:0] trial;
    logic [WIDTH:0] diff;

    // One restoring step: bring in the next dividend bit, subtract if it fits.
    always_comb begin
        trial  = {rem_i, bit_i};
        diff   = trial - {1'b0, dsr_i};
        qbit_o = (trial >= {1'b0, dsr_i});
        rem_o  = qbit_o ? diff[WIDTH-1:0] : trial[WIDTH-1:0];
    end
endmodule

// File: rtl/xdiv_unit.sv
module xdiv_unit #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             signed_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] quotient_o,
    output logic [WIDTH-1:0] remainder_o
);
    import xdiv_pkg::*;

    localparam int CW = $clog2(WIDTH + 1);

    typedef struct packed {
        xdiv_state_e      st;
        logic [WIDTH-1:0] dvd;    // raw dividend, then pre-shifted magnitude
        logic [WIDTH-1:0] dsr;    // raw divisor, then magnitude
        logic [WIDTH-1:0] quo;
        logic [WIDTH-1:0] rem;
        logic [CW-1:0]    cnt;    // iterations left
        logic             sgn;
        logic             neg_q;
        logic             neg_r;
    } xdiv_regs_t;

    xdiv_regs_t r_q, r_d;

    logic             neg_a, neg_b, div_zero;
    logic [WIDTH-1:0] mag_a, mag_b;
    logic [CW-1:0]    lz_a, shamt, iters;
    logic [WIDTH-1:0] step_rem;
    logic             step_qbit;
    logic [WIDTH-1:0] fix_quo, fix_rem;

    // Setup datapath: magnitudes and leading-zero count of the dividend.
    assign neg_a    = r_q.sgn & r_q.dvd[WIDTH-1];
    assign neg_b    = r_q.sgn & r_q.dsr[WIDTH-1];
    assign div_zero = (r_q.dsr == '0);

    xdiv_abs #(.WIDTH(WIDTH)) u_abs_a (.val_i(r_q.dvd), .neg_i(neg_a), .mag_o(mag_a));
    xdiv_abs #(.WIDTH(WIDTH)) u_abs_b (.val_i(r_q.dsr), .neg_i(neg_b), .mag_o(mag_b));

    xdiv_lzc #(.WIDTH(WIDTH), .CW(CW)) u_lzc (.val_i(mag_a), .lz_o(lz_a));

    // A zero divisor runs the full length so its timing is fixed.
    assign shamt = div_zero ? '0 : lz_a;
    assign iters = div_zero ? CW'(WIDTH) : (CW'(WIDTH) - lz_a);

    xdiv_step #(.WIDTH(WIDTH)) u_step (
        .rem_i  (r_q.rem),
        .bit_i  (r_q.dvd[WIDTH-1]),
        .dsr_i  (r_q.dsr),
        .rem_o  (step_rem),
        .qbit_o (step_qbit)
    );

    // Sign restoration; once written back with flags cleared it is a pass-through.
    xdiv_abs #(.WIDTH(WIDTH)) u_fix_q (.val_i(r_q.quo), .neg_i(r_q.neg_q), .mag_o(fix_quo));
    xdiv_abs #(.WIDTH(WIDTH)) u_fix_r (.val_i(r_q.rem), .neg_i(r_q.neg_r), .mag_o(fix_rem));

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st  = ST_SETUP;
                    r_d.dvd = dividend_i;
                    r_d.dsr = divisor_i;
                    r_d.sgn = signed_i;
                end
            end
            ST_SETUP: begin
                r_d.dvd   = mag_a << shamt;
                r_d.dsr   = mag_b;
                r_d.quo   = '0;
                r_d.rem   = '0;
                r_d.cnt   = iters;
                r_d.neg_q = (neg_a ^ neg_b) & ~div_zero;
                r_d.neg_r = neg_a;
                r_d.st    = (iters == '0) ? ST_FIX : ST_ITER;
            end
            ST_ITER: begin
                r_d.rem = step_rem;
                r_d.quo = {r_q.quo[WIDTH-2:0], step_qbit};
                r_d.dvd = r_q.dvd << 1;
                r_d.cnt = r_q.cnt - 1'b1;
                if (r_q.cnt == CW'(1)) begin
                    r_d.st = ST_FIX;
                end
            end
            ST_FIX: begin
                r_d.quo   = fix_quo;
                r_d.rem   = fix_rem;
                r_d.neg_q = 1'b0;
                r_d.neg_r = 1'b0;
                r_d.st    = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = (r_q.st != ST_IDLE);
    assign done_o      = (r_q.st == ST_FIX);
    assign quotient_o  = fix_quo;
    assign remainder_o = fix_rem;

endmodule

// File: rtl/xdiv_unit_chk.sv
module xdiv_unit_chk #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             signed_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    input  logic             busy_o,
    input  logic             done_o,
    input  logic [WIDTH-1:0] quotient_o,
    input  logic [WIDTH-1:0] remainder_o
);
    localparam int RW = $clog2(WIDTH + 3) + 1;
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    logic [RW-1:0]    run_q;
    logic [WIDTH-1:0] cap_a_q, cap_b_q;
    logic             cap_s_q;

    // Busy-cycle counter and operand capture, independent of the design state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= '0;
            cap_a_q <= '0;
            cap_b_q <= '0;
            cap_s_q <= 1'b0;
        end else begin
            run_q <= busy_o ? run_q + 1'b1 : '0;
            if (!busy_o && start_i) begin
                cap_a_q <= dividend_i;
                cap_b_q <= divisor_i;
                cap_s_q <= signed_i;
            end
        end
    end

    a_r1_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);
    a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r1_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
    a_r1_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);
    a_r1_rise_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
    a_r2_cycle_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_q >= RW'(1)) && (run_q <= RW'(WIDTH + 1)));
    a_r3_zero_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_a_q == '0 && cap_b_q != '0) |->
        (quotient_o == '0 && remainder_o == '0 && run_q == RW'(1)));
    a_r6_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_b_q == '0) |->
        (quotient_o == '1 && remainder_o == cap_a_q && run_q == RW'(WIDTH + 1)));
    a_r7_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_s_q && cap_a_q == MOST_NEG && cap_b_q == '1) |->
        (quotient_o == MOST_NEG && remainder_o == '0));
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o)));

endmodule

bind xdiv_unit xdiv_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .signed_i    (signed_i),
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o)
);

// File: tb/xdiv_unit_tb.sv
`timescale 1ns/1ps
module xdiv_unit_tb;
    localparam int W = 6;
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         sgn = 1'b0;
    logic [W-1:0] dvd = '0;
    logic [W-1:0] dsr = '0;
    logic         busy, done;
    logic [W-1:0] quo, rem;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    xdiv_unit #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .signed_i(sgn),
        .dividend_i(dvd), .divisor_i(dsr), .busy_o(busy), .done_o(done),
        .quotient_o(quo), .remainder_o(rem)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Reference results from the requirements.
    task automatic model(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                         output logic [W-1:0] q, output logic [W-1:0] r, output int cyc);
        int ia, ib, mag, bl;
        ia = s ? int'($signed(a)) : int'(a);
        ib = s ? int'($signed(b)) : int'(b);
        if (b == '0) begin
            q = '1;
            r = a;
            cyc = W + 2;
        end else begin
            q = W'(ia / ib);
            r = W'(ia % ib);
            mag = (ia < 0) ? -ia : ia;
            bl = 0;
            while (mag > 0) begin
                bl++;
                mag = mag >> 1;
            end
            cyc = bl + 2;
        end
    endtask

    // Issue one operation; optionally pulse start mid-run with other operands.
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                          input bit poke, output int cyc, output int gaps,
                          output logic [W-1:0] q, output logic [W-1:0] r);
        int n;
        @(negedge clk);
        chk("R1 idle before start", int'({busy, done}), 0);
        start = 1'b1; dvd = a; dsr = b; sgn = s;
        @(negedge clk);
        start = 1'b0;
        cyc = 0; gaps = 0; n = 0;
        forever begin
            if (busy) cyc++; else gaps++;
            if (done || n > 60) break;
            n++;
            @(negedge clk);
            start = poke && (n == 2);
            if (poke && n == 2) begin
                dvd = 6'd1; dsr = 6'd1; sgn = 1'b0;
            end
        end
        start = 1'b0;
        q = quo;
        r = rem;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cyc, gaps, ecyc;
        logic [W-1:0] q, r, eq, er;
        string tg, tc;

        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 busy", int'(busy), 0);
        chk("R10 done", int'(done), 0);
        chk("R10 quotient", int'(quo), 0);
        chk("R10 remainder", int'(rem), 0);
        rst_n = 1'b1;

        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < (1 << W); a++) begin
                for (int b = 0; b < (1 << W); b++) begin
                    run_op(W'(a), W'(b), s[0], 1'b0, cyc, gaps, q, r);
                    model(W'(a), W'(b), s[0], eq, er, ecyc);
                    if (b == 0) tg = "R6";
                    else if (s == 1 && W'(a) == MOST_NEG && W'(b) == '1) tg = "R7";
                    else if (a == 0) tg = "R3";
                    else if (s == 1) tg = "R5";
                    else tg = "R4";
                    tc = (b == 0) ? "R6 cycles" : ((a == 0) ? "R3 cycles" : "R2 cycles");
                    chk({tg, " quotient"}, int'(q), int'(eq));
                    chk({tg, " remainder"}, int'(r), int'(er));
                    chk(tc, cyc, ecyc);
                    chk("R1 busy continuous", gaps, 0);
                end
            end
        end

        // R8: a start during a long run is ignored.
        run_op(6'd31, 6'd0, 1'b0, 1'b1, cyc, gaps, q, r);
        chk("R8 quotient", int'(q), 63);
        chk("R8 remainder", int'(r), 31);
        chk("R8 cycles", cyc, W + 2);

        run_op(6'd45, 6'd7, 1'b0, 1'b1, cyc, gaps, q, r);
        chk("R8 quotient b", int'(q), 6);
        chk("R8 remainder b", int'(r), 3);
        chk("R8 cycles b", cyc, 8);

        // R9: results hold while idle even as operand inputs move.
        @(negedge clk);
        dvd = 6'd2; dsr = 6'd5; sgn = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 quotient held", int'(quo), 6);
        chk("R9 remainder held", int'(rem), 3);
        chk("R1 busy low after done", int'(busy), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule